// File: doc/BRIEF.md
# Context-Tagged Set-Associative Translation Buffer

This block caches virtual-to-physical page translations for a processor that keeps several address spaces resident at once. Each of its 64 entries holds an 8-bit address-space tag, a 19-bit virtual page number and a 19-bit physical page number; pages are 8 KB. The entries form 16 groups of four ways. A lookup searches only the group chosen by the low four bits of the page number. It hits when the entry tag equals the current-context register and the page numbers are equal.

Software owns the contents. It first writes an entry number to an index register. It then reads or writes that entry through a high word and a low word. The high word holds the tag and the page number; the low word holds the physical page. A fourth register holds the running context. The all-ones tag is reserved: the context register refuses it. An entry carrying that tag therefore never hits, which is how software clears an entry.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry holds tag 0xFF, virtual page 0 and physical page 0. The index and context registers are 0, `reg_rdata` is 0, and no lookup hits.
- R2: Register select 0 is the index register. A write stores `reg_wdata[5:0]`, and a read returns it in bits [5:0] with all other bits zero. Index bits [5:2] name the group and bits [1:0] the way.
- R3: Register select 1 is the high word of the selected entry. A write stores the tag from bits [7:0] and the virtual page from bits [31:13]. A read returns those two fields with bits [12:8] zero.
- R4: Register select 2 is the low word of the selected entry. A write stores the physical page from bits [31:13], and a read returns it with bits [12:0] zero.
- R5: `reg_rdata` takes the selected register's value at the clock edge where `reg_rd` is high. It holds its value on every other edge, even if the entry is rewritten.
- R6: A lookup hits only when an entry's tag equals the context register and its virtual page equals `lk_vaddr[31:13]`. On a hit, `lk_ppn` is that entry's physical page; on a miss, `lk_ppn` is zero. The result is combinational.
- R7: Only the four entries of group `lk_vaddr[16:13]` are searched. An entry placed in another group never hits for that address.
- R8: If more than one way of the group matches, the lowest-numbered way supplies `lk_ppn`.
- R9: Register select 3 is the context register, read back in bits [7:0]. A write of any value other than 0xFF loads bits [7:0]. A write of 0xFF is ignored.
- R10: An entry whose tag is 0xFF never hits. Rewriting a hitting entry with tag 0xFF and low word zero makes its address miss from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 index, 1 high, 2 low, 3 context |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 19 | Physical page number of the hit, zero on a miss |

## Verification
Some properties hold on every cycle, and the assertions check those. The context register never holds the reserved tag, and a write of 0xFF leaves it unchanged. A high-word write lands in the indexed entry. Read data holds when no read strobe is present. A hit implies a valid context, and a miss drives a zero page. Other behaviour needs the bench's directed and random scenarios, each compared with a reference model: group selection, lowest-way priority among duplicates, entry clearing, and exact read-back of every field.

// File: rtl/tlb_pkg.sv
// Package: register selects shared by the translation buffer modules.
// Assumes a two-bit register select on the software port.
package tlb_pkg;
    typedef enum logic [1:0] {
        RSEL_INDEX = 2'd0,
        RSEL_HIGH  = 2'd1,
        RSEL_LOW   = 2'd2,
        RSEL_CTX   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tlb_regif.sv
// Module: software register port. Holds the index and context registers,
// turns strobes into entry write enables and registers read data.
// Assumes the entry store presents the selected entry combinationally.
module tlb_regif
    import tlb_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PG_SHIFT = 13,
    parameter int TAG_W    = 8,
    parameter int IDX_W    = 6,
    localparam int VPN_W   = VA_W - PG_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [VA_W-1:0]  reg_wdata,
    output logic [VA_W-1:0]  reg_rdata,
    output logic [IDX_W-1:0] idx_q,
    output logic [TAG_W-1:0] ctx_q,
    output logic             hi_we,
    output logic             lo_we,
    output logic [TAG_W-1:0] wr_tag,
    output logic [VPN_W-1:0] wr_vpn,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [VPN_W-1:0] rd_vpn,
    input  logic [VPN_W-1:0] rd_ppn
);
    localparam logic [TAG_W-1:0] BAD_TAG = {TAG_W{1'b1}};

    reg_sel_e          sel;
    logic [VA_W-1:0]   rdata_d;
    logic              unused_bits;

    assign sel         = reg_sel_e'(reg_addr);
    assign hi_we       = reg_wr && (sel == RSEL_HIGH);
    assign lo_we       = reg_wr && (sel == RSEL_LOW);
    assign wr_tag      = reg_wdata[TAG_W-1:0];
    assign wr_vpn      = reg_wdata[VA_W-1:PG_SHIFT];
    assign unused_bits = ^reg_wdata[PG_SHIFT-1:TAG_W];

    // Index register: selects the entry seen through high/low words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (reg_wr && sel == RSEL_INDEX)
            idx_q <= reg_wdata[IDX_W-1:0];
    end

    // Context register: loads any tag except the reserved one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctx_q <= '0;
        else if (reg_wr && sel == RSEL_CTX && reg_wdata[TAG_W-1:0] != BAD_TAG)
            ctx_q <= reg_wdata[TAG_W-1:0];
    end

    // Read mux: formats the selected register as a full word.
    always_comb begin
        unique case (sel)
            RSEL_INDEX: rdata_d = VA_W'(idx_q);
            RSEL_HIGH:  rdata_d = {rd_vpn, {(PG_SHIFT-TAG_W){1'b0}}, rd_tag};
            RSEL_LOW:   rdata_d = {rd_ppn, {PG_SHIFT{1'b0}}};
            default:    rdata_d = VA_W'(ctx_q);
        endcase
    end

    // Read data register: captures only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rdata_d;
    end

    // R9
    ctx_never_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_q != BAD_TAG);

    // R9
    ctx_bad_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == RSEL_CTX && reg_wdata[TAG_W-1:0] == BAD_TAG) |=> $stable(ctx_q));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

// File: rtl/tlb_store.sv
// Module: entry storage for all groups and ways. Provides one port for
// software at the index and one group-wide read port for lookups.
// Assumes entry index = {group, way}.
module tlb_store #(
    parameter int GROUPS = 16,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 8,
    parameter int VPN_W  = 19,
    localparam int GRP_W   = $clog2(GROUPS),
    localparam int WAY_W   = $clog2(WAYS),
    localparam int ENTRIES = GROUPS * WAYS,
    localparam int IDX_W   = GRP_W + WAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_we,
    input  logic             lo_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [VPN_W-1:0] wr_ppn,
    output logic [TAG_W-1:0] sw_tag,
    output logic [VPN_W-1:0] sw_vpn,
    output logic [VPN_W-1:0] sw_ppn,
    input  logic [GRP_W-1:0] lk_grp,
    output logic [TAG_W-1:0] way_tag [WAYS],
    output logic [VPN_W-1:0] way_vpn [WAYS],
    output logic [VPN_W-1:0] way_ppn [WAYS]
);
    logic [TAG_W-1:0] tag_q [ENTRIES];
    logic [VPN_W-1:0] vpn_q [ENTRIES];
    logic [VPN_W-1:0] ppn_q [ENTRIES];

    // High-word fields: reset to the reserved tag, else written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                tag_q[e] <= {TAG_W{1'b1}};
                vpn_q[e] <= '0;
            end
        end else if (hi_we) begin
            tag_q[sw_idx] <= wr_tag;
            vpn_q[sw_idx] <= wr_vpn;
        end
    end

    // Low-word field: reset to zero, else written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++)
                ppn_q[e] <= '0;
        end else if (lo_we) begin
            ppn_q[sw_idx] <= wr_ppn;
        end
    end

    assign sw_tag = tag_q[sw_idx];
    assign sw_vpn = vpn_q[sw_idx];
    assign sw_ppn = ppn_q[sw_idx];

    // Group read port: one set of fields per way of the chosen group.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam logic [WAY_W-1:0] WSEL = WAY_W'(w);
        assign way_tag[w] = tag_q[{lk_grp, WSEL}];
        assign way_vpn[w] = vpn_q[{lk_grp, WSEL}];
        assign way_ppn[w] = ppn_q[{lk_grp, WSEL}];
    end

    // R3
    hi_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> (tag_q[$past(sw_idx)] == $past(wr_tag)) && (vpn_q[$past(sw_idx)] == $past(wr_vpn)));
endmodule

// File: rtl/tlb_match.sv
// Module: compares the ways of one group with the context and page,
// with fixed priority to the lowest way. Purely combinational.
// Assumes the reserved tag can never equal the context input.
module tlb_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    parameter int VPN_W = 19
) (
    input  logic [TAG_W-1:0] ctx,
    input  logic [VPN_W-1:0] vpn,
    input  logic [TAG_W-1:0] way_tag [WAYS],
    input  logic [VPN_W-1:0] way_vpn [WAYS],
    input  logic [VPN_W-1:0] way_ppn [WAYS],
    output logic             hit,
    output logic [VPN_W-1:0] ppn,
    output logic [WAYS-1:0]  win
);
    logic [WAYS-1:0] eq;

    // Per-way equality of tag and page.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = (way_tag[w] == ctx) && (way_vpn[w] == vpn);
    end

    // Priority pick: scan from the top so the lowest matching way wins.
    always_comb begin
        hit = 1'b0;
        ppn = '0;
        win = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) begin
                hit = 1'b1;
                ppn = way_ppn[w];
                win = WAYS'(1) << w;
            end
        end
    end
endmodule

// File: rtl/ctx_tlb.sv
// Module: top of the context-tagged translation buffer. Joins the
// register port, entry store and way matcher.
// Assumes 8 KB pages and a group chosen by the low page-number bits.
module ctx_tlb #(
    parameter int VA_W     = 32,
    parameter int PG_SHIFT = 13,
    parameter int TAG_W    = 8,
    parameter int GROUPS   = 16,
    parameter int WAYS     = 4,
    localparam int VPN_W   = VA_W - PG_SHIFT,
    localparam int GRP_W   = $clog2(GROUPS),
    localparam int IDX_W   = GRP_W + $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [VA_W-1:0]  reg_wdata,
    output logic [VA_W-1:0]  reg_rdata,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic [VPN_W-1:0] lk_ppn
);
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] ctx_q;
    logic             hi_we, lo_we;
    logic [TAG_W-1:0] wr_tag;
    logic [VPN_W-1:0] wr_vpn;
    logic [TAG_W-1:0] sw_tag;
    logic [VPN_W-1:0] sw_vpn, sw_ppn;
    logic [TAG_W-1:0] way_tag [WAYS];
    logic [VPN_W-1:0] way_vpn [WAYS];
    logic [VPN_W-1:0] way_ppn [WAYS];
    logic [VPN_W-1:0] lk_vpn;
    logic [WAYS-1:0]  win;

    assign lk_vpn = lk_vaddr[VA_W-1:PG_SHIFT];

    tlb_regif #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .TAG_W(TAG_W), .IDX_W(IDX_W)) regif_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .idx_q(idx_q), .ctx_q(ctx_q), .hi_we(hi_we), .lo_we(lo_we),
        .wr_tag(wr_tag), .wr_vpn(wr_vpn),
        .rd_tag(sw_tag), .rd_vpn(sw_vpn), .rd_ppn(sw_ppn)
    );

    tlb_store #(.GROUPS(GROUPS), .WAYS(WAYS), .TAG_W(TAG_W), .VPN_W(VPN_W)) store_i (
        .clk(clk), .rst_n(rst_n), .hi_we(hi_we), .lo_we(lo_we), .sw_idx(idx_q),
        .wr_tag(wr_tag), .wr_vpn(wr_vpn), .wr_ppn(wr_vpn),
        .sw_tag(sw_tag), .sw_vpn(sw_vpn), .sw_ppn(sw_ppn),
        .lk_grp(lk_vpn[GRP_W-1:0]),
        .way_tag(way_tag), .way_vpn(way_vpn), .way_ppn(way_ppn)
    );

    tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .VPN_W(VPN_W)) match_i (
        .ctx(ctx_q), .vpn(lk_vpn),
        .way_tag(way_tag), .way_vpn(way_vpn), .way_ppn(way_ppn),
        .hit(lk_hit), .ppn(lk_ppn), .win(win)
    );

    // R8
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win) && (lk_hit == (win != '0)));

    // R10
    hit_needs_valid_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (ctx_q != {TAG_W{1'b1}}));

    // R6
    miss_page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0));
endmodule

// File: tb/ctx_tlb_tb.sv
`timescale 1ns/1ps
module ctx_tlb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [18:0] lk_ppn;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference model state
    logic [7:0]  m_tag [64];
    logic [18:0] m_vpn [64];
    logic [18:0] m_ppn [64];
    logic [5:0]  m_idx;
    logic [7:0]  m_ctx;

    always #2.5 clk = ~clk;

    ctx_tlb dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_ppn(lk_ppn)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] ref_lookup(input logic [31:0] va);
        logic [18:0] vpn = va[31:13];
        for (int w = 0; w < 4; w++) begin
            int e = {vpn[3:0], 2'(w)};
            if (m_tag[e] == m_ctx && m_vpn[e] == vpn)
                return {1'b1, m_ppn[e]};
        end
        return 20'd0;
    endfunction

    function automatic logic [31:0] ref_read(input logic [1:0] a);
        case (a)
            2'd0: return {26'd0, m_idx};
            2'd1: return {m_vpn[m_idx], 5'd0, m_tag[m_idx]};
            2'd2: return {m_ppn[m_idx], 13'd0};
            default: return {24'd0, m_ctx};
        endcase
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            2'd0: m_idx = d[5:0];
            2'd1: begin m_tag[m_idx] = d[7:0]; m_vpn[m_idx] = d[31:13]; end
            2'd2: m_ppn[m_idx] = d[31:13];
            default: if (d[7:0] != 8'hFF) m_ctx = d[7:0];
        endcase
    endtask

    task automatic set_entry(input logic [5:0] i, input logic [7:0] t, input logic [18:0] v, input logic [18:0] p);
        wr(2'd0, {26'd0, i});
        wr(2'd1, {v, 5'd0, t});
        wr(2'd2, {p, 13'h1abc});
    endtask

    task automatic rd_chk(input logic [1:0] a, input string req);
        logic [31:0] exp;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp = ref_read(a);
        @(negedge clk);
        reg_rd = 1'b0;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic lk_chk(input logic [31:0] va, input string req);
        logic [19:0] exp;
        @(negedge clk);
        lk_vaddr = va;
        #1;
        exp = ref_lookup(va);
        check({lk_hit, lk_ppn} == exp, req, {12'd0, lk_hit, lk_ppn}, {12'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        for (int e = 0; e < 64; e++) begin m_tag[e] = 8'hFF; m_vpn[e] = '0; m_ppn[e] = '0; end
        m_idx = '0; m_ctx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 check(reg_rdata == 32'd0, "R1 rdata", reg_rdata, 32'd0);
        lk_chk(32'h0000_0000, "R1 lookup zero");
        lk_chk(32'h1234_5678, "R1 lookup other");
        rd_chk(2'd3, "R1 ctx");
        rd_chk(2'd0, "R1 index");
        rd_chk(2'd1, "R1 high");
        rd_chk(2'd2, "R1 low");

        // R2 / R3 / R4: field read-back
        wr(2'd0, 32'hFFFF_FFED);
        rd_chk(2'd0, "R2 index");
        wr(2'd1, 32'hABCD_FF42);
        rd_chk(2'd1, "R3 high");
        wr(2'd2, 32'hFFFF_FFFF);
        rd_chk(2'd2, "R4 low");

        // R5: rdata holds without a strobe
        held = reg_rdata;
        wr(2'd2, 32'h0000_2000);
        @(negedge clk);
        check(reg_rdata == held, "R5 hold", reg_rdata, held);

        // R9: context loads, reserved value ignored
        wr(2'd3, 32'h0000_0007);
        rd_chk(2'd3, "R9 ctx load");
        wr(2'd3, 32'h0000_00FF);
        rd_chk(2'd3, "R9 ctx ignore");

        // R6: hit on matching tag and page
        set_entry(6'd20, 8'h07, 19'h00125, 19'h4_0001);
        lk_chk({19'h00125, 13'h0444}, "R6 hit");
        lk_chk({19'h00135, 13'h0000}, "R6 page miss");
        wr(2'd3, 32'h0000_0008);
        lk_chk({19'h00125, 13'h0000}, "R6 ctx miss");
        wr(2'd3, 32'h0000_0007);

        // R7: entry in the wrong group never hits
        set_entry(6'd0, 8'h07, 19'h00035, 19'h1_1111);
        lk_chk({19'h00035, 13'h0000}, "R7 wrong group");

        // R8: duplicates in group 2, lowest way wins
        set_entry(6'd11, 8'h07, 19'h00072, 19'h3_3333);
        set_entry(6'd9,  8'h07, 19'h00072, 19'h2_2222);
        lk_chk({19'h00072, 13'h0010}, "R8 lowest way");

        // R10: clearing way 1 exposes way 3; reserved-tag entry never hits
        wr(2'd0, 32'd9);
        wr(2'd1, {19'h00072, 5'd0, 8'hFF});
        wr(2'd2, 32'd0);
        lk_chk({19'h00072, 13'h0010}, "R10 cleared");
        set_entry(6'd11, 8'hFF, 19'h00072, 19'h3_3333);
        wr(2'd3, 32'h0000_00FF);
        lk_chk({19'h00072, 13'h0010}, "R10 bad tag");

        // Random mix: R2 R3 R4 R6 R7 R8 R9 R10
        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 9);
            logic [18:0] v = {13'd0, 2'($urandom_range(0, 3)), 4'($urandom)};
            logic [7:0]  t = ($urandom_range(0, 5) == 0) ? 8'hFF : 8'($urandom_range(0, 3));
            if (op < 3)
                set_entry(6'($urandom), t, v, 19'($urandom));
            else if (op == 3)
                wr(2'd3, {24'd0, t});
            else if (op == 4)
                rd_chk(2'($urandom), "R2 R3 R4 R9 random read");
            else
                lk_chk({v, 13'($urandom)}, "R6 R7 R8 R10 random lookup");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule